// File: doc/BRIEF.md
# Flash Write-Protection and Status Controller

This block sits between the serial command decoder of a small flash memory and its array engine. It holds the 8-bit status byte and decides, one request at a time, whether a write-enable change, a status write, a page program, a sector erase or a whole-array erase may proceed. A request reaches the block as a single-cycle strobe carrying an operation code, an address, a data byte and a flag. The decoder raises the flag when the frame ended on a byte boundary. The block then answers with a one-cycle accepted or refused pulse.

Accepted program and erase requests produce a one-cycle execute strobe toward the array engine, carrying the operation, the address and the sector. Every accepted write-class request also starts a self-timed busy cycle whose length, in clock ticks, is a parameter for each kind of operation. The write-in-progress flag stays high for that whole cycle. At its end the flag and the write-enable latch drop together.

Protection works on two levels. The two protect bits lock the whole array when either of them is set. The status-write-disable bit, together with a low write-protect pin, freezes the status byte itself until the pin returns high.

Top module: `flash_wp_ctrl`

## Requirements
- R1: After reset the status byte reads 00h. Its layout is bit 7 status-write-disable, bits 6..4 always 0, bit 3 protect-high, bit 2 protect-low, bit 1 write-enable latch, bit 0 write-in-progress.
- R2: An accepted enable request (op code 1) sets the write-enable latch and an accepted disable request (op code 2) clears it. Neither one starts a busy cycle.
- R3: A write-class request (status write 3, program 4, sector erase 5, array erase 6) made while the write-enable latch is 0 is refused. The latch, the busy flag and the execute strobe are left unchanged.
- R4: A write-class request whose frame-complete flag is 0 is refused, and the latch stays set.
- R5: An accepted status write copies data bits 7, 3 and 2 into the matching status bits and leaves every other bit unaffected.
- R6: While status bit 7 is 1 and the write-protect pin is low, a status write is refused. Once the pin is high the same request is accepted.
- R7: A program or sector-erase request is refused when either protect bit is 1 and accepted when both are 0, given the latch is set.
- R8: An array-erase request is accepted only when both protect bits are 0.
- R9: An accepted write-class request raises the busy flag in the cycle after the request and holds it for exactly the configured number of cycles. Its value is T_STWR, T_PROG, T_SECER or T_CHIPER. The busy flag and the latch fall in the same cycle.
- R10: Any request made while the busy flag is 1 is refused and changes nothing, including enable and disable requests.
- R11: The accepted/refused pulse appears one cycle after the request, and the two never occur together. For an accepted program or erase, an execute strobe appears in that same cycle with the op code, the address, and the sector given by the address MSB (0 for 0000h-7FFFh, 1 for 8000h-FFFFh).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wp_n_i | input | 1 | Write-protect pin, low asserts protection |
| req_i | input | 1 | Request strobe, one cycle |
| req_op_i | input | 3 | Operation code (1..6) |
| req_addr_i | input | ADDR_W | Target address |
| req_data_i | input | 8 | Status write data |
| req_frame_ok_i | input | 1 | Frame ended on a byte boundary |
| status_o | output | 8 | Status byte |
| acc_o | output | 1 | Request accepted pulse |
| rej_o | output | 1 | Request refused pulse |
| exec_valid_o | output | 1 | Execute strobe toward the array engine |
| exec_op_o | output | 3 | Operation being executed |
| exec_addr_o | output | ADDR_W | Address being executed |
| exec_sector_o | output | 1 | Sector of the executed address |

## Verification
The hardest situation to reach is the hardware lock. The status-write-disable bit can only be set through an accepted status write, and that write needs the latch and an idle busy timer. Only after that can the pin be pulled low and a second, enabled status write be attempted. The stimulus builds this chain step by step and waits out each busy cycle in between. It then releases the pin and repeats the same write to show that the lock lifts. A behavioural model in the bench tracks latch, protect bits and the remaining busy ticks, and compares against the outputs on every cycle.

// File: rtl/fwp_pkg.sv
package fwp_pkg;

   typedef enum logic [2:0] {
      OP_NONE   = 3'd0,
      OP_WEN    = 3'd1,
      OP_WDIS   = 3'd2,
      OP_STWR   = 3'd3,
      OP_PROG   = 3'd4,
      OP_SECER  = 3'd5,
      OP_CHIPER = 3'd6
   } fwp_op_e;

   localparam int unsigned SB_WIP  = 0;
   localparam int unsigned SB_WEL  = 1;
   localparam int unsigned SB_BP0  = 2;
   localparam int unsigned SB_SRWD = 7;
   localparam int unsigned NUM_BP  = 2;

   function automatic logic is_array_op(fwp_op_e op);
      return (op == OP_PROG) || (op == OP_SECER) || (op == OP_CHIPER);
   endfunction

   function automatic logic is_timed_op(fwp_op_e op);
      return (op == OP_STWR) || is_array_op(op);
   endfunction

endpackage

// File: rtl/fwp_policy.sv
module fwp_policy
   import fwp_pkg::*;
(
   input  logic                req,
   input  fwp_op_e             op,
   input  logic                frame_ok,
   input  logic                wel,
   input  logic                wip,
   input  logic                srwd,
   input  logic [NUM_BP-1:0]   bp,
   input  logic                wp_n,
   output logic                accept,
   output logic                refuse
);

   logic grant;
   logic hw_locked;
   logic any_protect;

   assign hw_locked   = srwd & ~wp_n;
   assign any_protect = |bp;

   always_comb begin
      grant = 1'b0;
      unique case (op)
         OP_WEN, OP_WDIS:             grant = 1'b1;
         OP_STWR:                     grant = wel & frame_ok & ~hw_locked;
         OP_PROG, OP_SECER, OP_CHIPER: grant = wel & frame_ok & ~any_protect;
         default:                     grant = 1'b0;
      endcase
   end

   assign accept = req & ~wip & grant;
   assign refuse = req & ~accept;

endmodule

// File: rtl/fwp_busy_timer.sv
module fwp_busy_timer
   import fwp_pkg::*;
#(
   parameter int unsigned T_STWR   = 250000,
   parameter int unsigned T_PROG   = 250000,
   parameter int unsigned T_SECER  = 100000000,
   parameter int unsigned T_CHIPER = 200000000
) (
   input  logic    clk,
   input  logic    rst_n,
   input  logic    start,
   input  fwp_op_e op,
   output logic    wip,
   output logic    last
);

   localparam int unsigned T_MAX_A = (T_STWR > T_PROG) ? T_STWR : T_PROG;
   localparam int unsigned T_MAX_B = (T_SECER > T_CHIPER) ? T_SECER : T_CHIPER;
   localparam int unsigned T_MAX   = (T_MAX_A > T_MAX_B) ? T_MAX_A : T_MAX_B;
   localparam int unsigned CNT_W   = $clog2(T_MAX + 1);

   initial begin
      assert (T_STWR >= 1 && T_PROG >= 1 && T_SECER >= 1 && T_CHIPER >= 1)
         else $error("fwp_busy_timer: every duration must be at least one tick");
   end

   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] load_val;

   always_comb begin
      unique case (op)
         OP_STWR:  load_val = CNT_W'(T_STWR);
         OP_PROG:  load_val = CNT_W'(T_PROG);
         OP_SECER: load_val = CNT_W'(T_SECER);
         default:  load_val = CNT_W'(T_CHIPER);
      endcase
   end

   assign last = wip & (cnt_q == CNT_W'(1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wip   <= 1'b0;
         cnt_q <= '0;
      end else if (start) begin
         wip   <= 1'b1;
         cnt_q <= load_val;
      end else if (last) begin
         wip   <= 1'b0;
         cnt_q <= '0;
      end else if (wip) begin
         cnt_q <= cnt_q - CNT_W'(1);
      end
   end

endmodule

// File: rtl/fwp_status_reg.sv
module fwp_status_reg
   import fwp_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              accept,
   input  fwp_op_e           op,
   input  logic [7:0]        data,
   input  logic              cycle_last,
   output logic              wel,
   output logic              srwd,
   output logic [NUM_BP-1:0] bp
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wel <= 1'b0;
      end else if (cycle_last) begin
         wel <= 1'b0;
      end else if (accept && op == OP_WEN) begin
         wel <= 1'b1;
      end else if (accept && op == OP_WDIS) begin
         wel <= 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         srwd <= 1'b0;
      end else if (accept && op == OP_STWR) begin
         srwd <= data[SB_SRWD];
      end
   end

   for (genvar gi = 0; gi < NUM_BP; gi++) begin : g_bp
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            bp[gi] <= 1'b0;
         end else if (accept && op == OP_STWR) begin
            bp[gi] <= data[SB_BP0 + gi];
         end
      end
   end

endmodule

// File: rtl/flash_wp_ctrl.sv
module flash_wp_ctrl
   import fwp_pkg::*;
#(
   parameter int unsigned ADDR_W   = 16,
   parameter int unsigned T_STWR   = 250000,
   parameter int unsigned T_PROG   = 250000,
   parameter int unsigned T_SECER  = 100000000,
   parameter int unsigned T_CHIPER = 200000000
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wp_n_i,
   input  logic              req_i,
   input  logic [2:0]        req_op_i,
   input  logic [ADDR_W-1:0] req_addr_i,
   input  logic [7:0]        req_data_i,
   input  logic              req_frame_ok_i,
   output logic [7:0]        status_o,
   output logic              acc_o,
   output logic              rej_o,
   output logic              exec_valid_o,
   output logic [2:0]        exec_op_o,
   output logic [ADDR_W-1:0] exec_addr_o,
   output logic              exec_sector_o
);

   localparam int unsigned SECTOR_BIT = ADDR_W - 1;

   initial begin
      assert (ADDR_W >= 2) else $error("flash_wp_ctrl: ADDR_W too small");
   end

   fwp_op_e           op;
   logic              accept;
   logic              refuse;
   logic              wel;
   logic              wip;
   logic              srwd;
   logic [NUM_BP-1:0] bp;
   logic              cycle_last;
   logic              start_cycle;

   assign op          = fwp_op_e'(req_op_i);
   assign start_cycle = accept & is_timed_op(op);

   fwp_policy u_policy (
      .req      (req_i),
      .op       (op),
      .frame_ok (req_frame_ok_i),
      .wel      (wel),
      .wip      (wip),
      .srwd     (srwd),
      .bp       (bp),
      .wp_n     (wp_n_i),
      .accept   (accept),
      .refuse   (refuse)
   );

   fwp_busy_timer #(
      .T_STWR   (T_STWR),
      .T_PROG   (T_PROG),
      .T_SECER  (T_SECER),
      .T_CHIPER (T_CHIPER)
   ) u_timer (
      .clk   (clk),
      .rst_n (rst_n),
      .start (start_cycle),
      .op    (op),
      .wip   (wip),
      .last  (cycle_last)
   );

   fwp_status_reg u_sreg (
      .clk        (clk),
      .rst_n      (rst_n),
      .accept     (accept),
      .op         (op),
      .data       (req_data_i),
      .cycle_last (cycle_last),
      .wel        (wel),
      .srwd       (srwd),
      .bp         (bp)
   );

   always_comb begin
      status_o                          = '0;
      status_o[SB_SRWD]                 = srwd;
      status_o[SB_BP0 +: NUM_BP]        = bp;
      status_o[SB_WEL]                  = wel;
      status_o[SB_WIP]                  = wip;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc_o         <= 1'b0;
         rej_o         <= 1'b0;
         exec_valid_o  <= 1'b0;
         exec_op_o     <= '0;
         exec_addr_o   <= '0;
         exec_sector_o <= 1'b0;
      end else begin
         acc_o        <= accept;
         rej_o        <= refuse;
         exec_valid_o <= accept & is_array_op(op);
         if (accept && is_array_op(op)) begin
            exec_op_o     <= req_op_i;
            exec_addr_o   <= req_addr_i;
            exec_sector_o <= req_addr_i[SECTOR_BIT];
         end
      end
   end

endmodule

// File: rtl/fwp_chk.sv
module fwp_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       wp_n_i,
   input logic [7:0] status_o,
   input logic       acc_o,
   input logic       rej_o,
   input logic       exec_valid_o,
   input logic [2:0] exec_op_o
);

   p_reserved_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
      status_o[6:4] == 3'b000);

   p_exec_needs_wel_r3: assert property (@(posedge clk) disable iff (!rst_n)
      exec_valid_o |-> $past(status_o[1]));

   p_hw_lock_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (status_o[7] && !wp_n_i) |=> ($stable(status_o[7]) && $stable(status_o[3:2])));

   p_bulk_unprot_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (exec_valid_o && exec_op_o == 3'd6) |-> ($past(status_o[3:2]) == 2'b00));

   p_wel_with_wip_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(status_o[0]) |-> !status_o[1]);

   p_busy_drops_r10: assert property (@(posedge clk) disable iff (!rst_n)
      status_o[0] |=> (!acc_o && !exec_valid_o));

   p_acc_rej_excl_r11: assert property (@(posedge clk) disable iff (!rst_n)
      !(acc_o && rej_o));

endmodule

bind flash_wp_ctrl fwp_chk u_fwp_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .wp_n_i       (wp_n_i),
   .status_o     (status_o),
   .acc_o        (acc_o),
   .rej_o        (rej_o),
   .exec_valid_o (exec_valid_o),
   .exec_op_o    (exec_op_o)
);

// File: tb/flash_wp_ctrl_tb_top.sv
`timescale 1ns/1ps
module flash_wp_ctrl_tb_top;

   localparam int ADDR_W = 16;
   localparam int T_ST = 5, T_PG = 7, T_SE = 11, T_CE = 13;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              wp_n = 1'b1;
   logic              req = 1'b0;
   logic [2:0]        op = '0;
   logic [ADDR_W-1:0] addr = '0;
   logic [7:0]        data = '0;
   logic              fok = 1'b1;
   logic [7:0]        status;
   logic              acc, rej, exv, exsec;
   logic [2:0]        exop;
   logic [ADDR_W-1:0] exaddr;

   int total = 0;
   int bad = 0;
   bit done = 0;

   always #10 clk = ~clk;

   flash_wp_ctrl #(
      .ADDR_W(ADDR_W), .T_STWR(T_ST), .T_PROG(T_PG), .T_SECER(T_SE), .T_CHIPER(T_CE)
   ) dut_i (
      .clk(clk), .rst_n(rst_n), .wp_n_i(wp_n), .req_i(req), .req_op_i(op),
      .req_addr_i(addr), .req_data_i(data), .req_frame_ok_i(fok),
      .status_o(status), .acc_o(acc), .rej_o(rej), .exec_valid_o(exv),
      .exec_op_o(exop), .exec_addr_o(exaddr), .exec_sector_o(exsec)
   );

   // behavioural reference model
   int m_wel = 0, m_srwd = 0, m_bp = 0, m_left = 0;
   int m_acc = 0, m_rej = 0, m_exv = 0, m_exop = 0, m_exaddr = 0;

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_wel = 0; m_srwd = 0; m_bp = 0; m_left = 0;
         m_acc = 0; m_rej = 0; m_exv = 0;
      end else begin : step
         bit busy;
         bit ok;
         busy = (m_left > 0);
         m_acc = 0; m_rej = 0; m_exv = 0;
         if (busy) begin
            m_left = m_left - 1;
            if (m_left == 0) m_wel = 0;
         end
         if (req) begin
            ok = 0;
            if (!busy) begin
               case (int'(op))
                  1, 2:    ok = 1;
                  3:       ok = (m_wel == 1) && fok && !(m_srwd == 1 && !wp_n);
                  4, 5, 6: ok = (m_wel == 1) && fok && (m_bp == 0);
                  default: ok = 0;
               endcase
            end
            if (ok) begin
               m_acc = 1;
               case (int'(op))
                  1: m_wel = 1;
                  2: m_wel = 0;
                  3: begin m_srwd = data[7]; m_bp = data[3:2]; m_left = T_ST; end
                  4: m_left = T_PG;
                  5: m_left = T_SE;
                  default: m_left = T_CE;
               endcase
               if (op >= 3'd4) begin
                  m_exv = 1; m_exop = op; m_exaddr = addr;
               end
            end else begin
               m_rej = 1;
            end
         end
      end
   end

   task automatic check(input string tag, input int act, input int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
      end
   endtask

   // per-cycle comparison against the model
   always @(negedge clk) begin
      if (rst_n && !done) begin
         check("R9 wip", status[0], m_left > 0);
         check("R2 wel", status[1], m_wel);
         check("R5 protect/lock bits", {status[7], status[3:2]}, {m_srwd[0], m_bp[1:0]});
         check("R1 reserved bits", status[6:4], 0);
         check("R11 accept", acc, m_acc);
         check("R3 refuse", rej, m_rej);
         check("R11 exec valid", exv, m_exv);
         if (m_exv == 1) begin
            check("R11 exec op", exop, m_exop);
            check("R11 exec addr", exaddr, m_exaddr);
            check("R11 exec sector", exsec, m_exaddr[ADDR_W-1]);
         end
      end
   end

   task automatic issue(input int o, input int a, input int d, input bit f);
      @(negedge clk);
      req = 1'b1; op = 3'(o); addr = ADDR_W'(a); data = 8'(d); fok = f;
      @(negedge clk);
      req = 1'b0; fok = 1'b1;
   endtask

   task automatic wait_idle();
      while (status[0]) @(negedge clk);
   endtask

   initial begin : wdog
      repeat (20000) @(posedge clk);
      if (!done) begin
         done = 1;
         total++; bad++;
         $display("FAIL watchdog expired");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin : main
      int n;
      repeat (3) @(negedge clk);
      check("R1 reset status", status, 8'h00);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 status after reset release", status, 8'h00);

      issue(4, 'h0100, 0, 1);
      check("R3 program without latch refused", {acc, rej, exv}, 3'b010);
      check("R3 no busy after refusal", status, 8'h00);

      issue(1, 0, 0, 1);
      check("R2 enable sets latch", status, 8'h02);
      issue(2, 0, 0, 1);
      check("R2 disable clears latch", status, 8'h00);
      issue(1, 0, 0, 1);

      issue(4, 'h0100, 0, 0);
      check("R4 bad frame refused", {acc, rej}, 2'b01);
      check("R4 latch kept", status, 8'h02);

      issue(4, 'h9000, 0, 1);
      check("R11 exec for program", {acc, exv, exsec}, 3'b111);
      check("R11 exec addr", exaddr, 'h9000);
      n = 0;
      while (status[0]) begin
         n++;
         if (n == 2) begin
            req = 1'b1; op = 3'd2;
         end else begin
            req = 1'b0;
         end
         @(negedge clk);
         if (n == 2) check("R10 disable during busy refused", {rej, status[1]}, 2'b11);
      end
      req = 1'b0;
      check("R9 busy length program", n, T_PG);
      check("R9 latch cleared at end", status, 8'h00);

      issue(1, 0, 0, 1);
      issue(3, 0, 'hFF, 1);
      check("R5 status write bits", status, 8'h8F);
      wait_idle();
      check("R5 after status cycle", status, 8'h8C);

      issue(1, 0, 0, 1);
      issue(4, 'h0010, 0, 1);
      check("R7 program refused when protected", {acc, rej}, 2'b01);
      issue(5, 'h0010, 0, 1);
      check("R7 sector erase refused when protected", {acc, rej}, 2'b01);
      issue(6, 0, 0, 1);
      check("R8 array erase refused when protected", {acc, rej, exv}, 3'b010);

      wp_n = 1'b0;
      issue(3, 0, 'h00, 1);
      check("R6 status write locked", {acc, rej}, 2'b01);
      check("R6 status unchanged", status, 8'h8E);
      wp_n = 1'b1;
      issue(3, 0, 'h00, 1);
      check("R6 unlocked status write accepted", acc, 1);
      wait_idle();
      check("R6 status cleared", status, 8'h00);

      issue(1, 0, 0, 1);
      issue(6, 0, 0, 1);
      check("R8 array erase accepted", {acc, exv, exop}, {2'b11, 3'd6});
      wait_idle();
      issue(1, 0, 0, 1);
      issue(5, 'h1234, 0, 1);
      check("R7 sector erase accepted sector 0", {acc, exv, exsec}, 3'b110);
      wait_idle();
      check("R9 idle after erase", status, 8'h00);

      repeat (3) @(negedge clk);
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule